// File: doc/BRIEF.md
# Station Power-Save Wake Scheduler

This block decides when a power-saving wireless station powers its receiver up and when it may power it down again. Software loads two target beacon times in TU (an ordinary beacon that may carry a traffic indication, and a delivery beacon that announces buffered broadcast traffic) together with a period in TU for each. The block turns each target into a wake time on a free-running time base counted in 1/8 TU. The wake time is a fixed slop of 3 TU ahead of the beacon, so the radio is ready before the frame arrives.

After waking, the block waits a bounded time for the beacon. A beacon that asks for no broadcast follow-up holds the station awake until software sends a sleep command. A delivery beacon, when the assume-broadcast option is set, or any beacon seen while the more-broadcast indication is high, opens a bounded window for the buffered broadcast frames. This window is extended for as long as more broadcast data is flagged. If the beacon wait or the broadcast window runs out, the station goes back to sleep.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle strobe, and no input is ever back-pressured.

Top module: `pswake_ctrl`

## Requirements
- R1: After reset, awake, why_tim, why_dtim and cab_wait are all 0, and no wake happens until a schedule has been loaded.
- R2: A cfg_load strobe sets each wake time to (beacon TU × 8) − 24 in 1/8 TU. awake rises in the cycle after the first clock edge at which now_i, read as a signed difference, has reached that wake time.
- R3: If cfg_tim_per equals cfg_dtim_per when cfg_load is sampled, the ordinary-beacon schedule takes the delivery-beacon target and cfg_tim_tu is ignored. The station then wakes only for delivery beacons.
- R4: At every edge where a schedule's wake time is reached while enabled, that wake time advances by its period × 8, whatever the current state. If both are reached together, both advance and the wake is treated as a delivery wake.
- R5: If no beacon_rx arrives within 80 eighths (10 TU) of the wake, the block returns to sleep.
- R6: A beacon that leads to no broadcast window holds the block awake until sleep_cmd. sleep_cmd has no effect while the block waits for a beacon or is in a broadcast window.
- R7: After a delivery-wake beacon with cfg_assume_dtim=1, cab_wait goes to 1. With cfg_assume_dtim=0 and more_bcast=0, the block holds awake instead.
- R8: A beacon seen with more_bcast=1 opens the broadcast window. Each edge with more_bcast=1 in the window restarts it, and it closes to sleep 80 eighths after the last restart.
- R9: While cfg_en=0, the block is asleep with both reason flags clear, no wake occurs and the schedules stay frozen.
- R10: why_tim and why_dtim show which schedules triggered the current wake, and both are 0 whenever awake is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_i | input | TW | Time base in 1/8 TU |
| cfg_load | input | 1 | Strobe that loads targets and periods |
| cfg_tim_tu | input | TW | Next ordinary-beacon time in TU |
| cfg_dtim_tu | input | TW | Next delivery-beacon time in TU |
| cfg_tim_per | input | PW | Ordinary-beacon period in TU |
| cfg_dtim_per | input | PW | Delivery-beacon period in TU |
| cfg_en | input | 1 | Scheduler enable |
| cfg_assume_dtim | input | 1 | Treat a delivery wake as carrying broadcast data |
| beacon_rx | input | 1 | Beacon received, one cycle |
| more_bcast | input | 1 | More broadcast data is flagged |
| sleep_cmd | input | 1 | Software request to sleep |
| awake | output | 1 | Receiver power request |
| why_tim | output | 1 | Current wake came from the ordinary schedule |
| why_dtim | output | 1 | Current wake came from the delivery schedule |
| cab_wait | output | 1 | Broadcast window open |

## Verification
Every output is registered once, so the effect of the inputs sampled at one edge shows up in the cycle after that edge. A wake seen at time W is visible when the time base reads W+1, and a timeout that starts at time S ends visibly at S+81. The bench drives inputs just after an edge and samples one time unit later. Its directed checks are written against the time base value at which each result is due, and a cycle model with the same one-edge latency is compared on every cycle during the random phase.

// File: rtl/pswake_pkg.sv
package pswake_pkg;
  typedef enum logic [1:0] {
    PS_SLEEP = 2'd0,
    PS_BCN   = 2'd1,
    PS_CAB   = 2'd2,
    PS_HOLD  = 2'd3
  } ps_state_e;
endpackage

// File: rtl/pswake_sched.sv
module pswake_sched #(
  parameter int TW      = 32,
  parameter int PW      = 16,
  parameter int SLOP_TU = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_tu,
  input  logic [PW-1:0] period_tu,
  input  logic          adv,
  input  logic [TW-1:0] now,
  output logic          hit
);
  localparam logic [TW-1:0] SLOP8 = TW'(SLOP_TU * 8);
  localparam int PADW = TW - PW - 3;

  logic [TW-1:0] wake_q;
  logic [TW-1:0] step_q;
  logic          armed_q;
  logic [TW-1:0] diff;

  assign diff = now - wake_q;
  assign hit  = armed_q && !diff[TW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= '0;
      step_q  <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      wake_q  <= {load_tu[TW-4:0], 3'b000} - SLOP8;
      step_q  <= {{PADW{1'b0}}, period_tu, 3'b000};
      armed_q <= 1'b1;
    end else if (adv) begin
      wake_q  <= wake_q + step_q;
    end
  end

  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (wake_q == $past(wake_q) + $past(step_q)));

  // R2
  armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
endmodule

// File: rtl/pswake_window.sv
module pswake_window #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] now,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= '0;
    else if (restart) start_q <= now;
  end

  assign expired = (now - start_q) >= limit;
endmodule

// File: rtl/pswake_ctrl.sv
module pswake_ctrl
  import pswake_pkg::*;
#(
  parameter int TW        = 32,
  parameter int PW        = 16,
  parameter int SLOP_TU   = 3,
  parameter int BCN_TO_TU = 10,
  parameter int CAB_TO_TU = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_tim_tu,
  input  logic [TW-1:0] cfg_dtim_tu,
  input  logic [PW-1:0] cfg_tim_per,
  input  logic [PW-1:0] cfg_dtim_per,
  input  logic          cfg_en,
  input  logic          cfg_assume_dtim,
  input  logic          beacon_rx,
  input  logic          more_bcast,
  input  logic          sleep_cmd,
  output logic          awake,
  output logic          why_tim,
  output logic          why_dtim,
  output logic          cab_wait
);
  localparam int NSCH = 2;
  localparam logic [TW-1:0] BCN_LIM = TW'(BCN_TO_TU * 8);
  localparam logic [TW-1:0] CAB_LIM = TW'(CAB_TO_TU * 8);

  ps_state_e st_q, st_d;
  logic why_t_q, why_d_q;

  logic [TW-1:0] ld_tu  [NSCH];
  logic [PW-1:0] ld_per [NSCH];
  logic [NSCH-1:0] hit, adv;
  logic align, wake_go, to_cab, restart, win_expired;
  logic [TW-1:0] win_limit;

  // slot 0: ordinary-beacon schedule, slot 1: delivery-beacon schedule
  assign align     = (cfg_tim_per == cfg_dtim_per);
  assign ld_tu[0]  = align ? cfg_dtim_tu : cfg_tim_tu;
  assign ld_tu[1]  = cfg_dtim_tu;
  assign ld_per[0] = cfg_tim_per;
  assign ld_per[1] = cfg_dtim_per;

  generate
    for (genvar g = 0; g < NSCH; g++) begin : g_sched
      pswake_sched #(.TW(TW), .PW(PW), .SLOP_TU(SLOP_TU)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .load_tu   (ld_tu[g]),
        .period_tu (ld_per[g]),
        .adv       (adv[g]),
        .now       (now_i),
        .hit       (hit[g])
      );
    end
  endgenerate

  assign adv     = cfg_en ? hit : '0;
  assign wake_go = (st_q == PS_SLEEP) && (|adv);
  assign to_cab  = more_bcast || (why_d_q && cfg_assume_dtim);
  assign restart = wake_go
                || ((st_q == PS_BCN) && beacon_rx && to_cab)
                || ((st_q == PS_CAB) && more_bcast);
  assign win_limit = (st_q == PS_CAB) ? CAB_LIM : BCN_LIM;

  pswake_window #(.TW(TW)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .now     (now_i),
    .limit   (win_limit),
    .expired (win_expired)
  );

  always_comb begin
    st_d = st_q;
    if (!cfg_en) begin
      st_d = PS_SLEEP;
    end else begin
      unique case (st_q)
        PS_SLEEP: if (wake_go) st_d = PS_BCN;
        PS_BCN: begin
          if (beacon_rx)        st_d = to_cab ? PS_CAB : PS_HOLD;
          else if (win_expired) st_d = PS_SLEEP;
        end
        PS_CAB:  if (!more_bcast && win_expired) st_d = PS_SLEEP;
        PS_HOLD: if (sleep_cmd) st_d = PS_SLEEP;
        default: st_d = PS_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_SLEEP;
      why_t_q <= 1'b0;
      why_d_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == PS_SLEEP) begin
        why_t_q <= 1'b0;
        why_d_q <= 1'b0;
      end else if (wake_go) begin
        why_t_q <= adv[0];
        why_d_q <= adv[1];
      end
    end
  end

  assign awake    = (st_q != PS_SLEEP);
  assign why_tim  = why_t_q;
  assign why_dtim = why_d_q;
  assign cab_wait = (st_q == PS_CAB);

  // R6
  hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HOLD && cfg_en && !sleep_cmd) |=> (st_q == PS_HOLD));

  // R5
  bcn_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_BCN && cfg_en && !beacon_rx && win_expired) |=> !awake);

  // R8
  cab_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_CAB && cfg_en && more_bcast) |=> cab_wait);

  // R9
  disable_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!awake && !why_tim && !why_dtim));

  // R10
  reason_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !(why_tim || why_dtim));

  // R10
  reason_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> (why_tim || why_dtim));
endmodule

// File: tb/pswake_ctrl_bench.sv
`timescale 1ns/1ps
module pswake_ctrl_bench;
  localparam int TW = 32;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] now_t = '0;
  logic cfg_load = 0, cfg_en = 0, cfg_assume_dtim = 0;
  logic [TW-1:0] cfg_tim_tu = '0, cfg_dtim_tu = '0;
  logic [PW-1:0] cfg_tim_per = '0, cfg_dtim_per = '0;
  logic beacon_rx = 0, more_bcast = 0, sleep_cmd = 0;
  logic awake, why_tim, why_dtim, cab_wait;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state: 0 sleep, 1 beacon wait, 2 broadcast window, 3 hold
  int m_st = 0;
  logic [TW-1:0] m_wt = '0, m_wd = '0, m_step_t = '0, m_step_d = '0, m_start = '0;
  bit m_armed = 0, m_why_t = 0, m_why_d = 0;

  always #2 clk = ~clk;

  pswake_ctrl #(.TW(TW), .PW(PW)) u_pswake_ctrl (
    .clk(clk), .rst_n(rst_n), .now_i(now_t),
    .cfg_load(cfg_load), .cfg_tim_tu(cfg_tim_tu), .cfg_dtim_tu(cfg_dtim_tu),
    .cfg_tim_per(cfg_tim_per), .cfg_dtim_per(cfg_dtim_per),
    .cfg_en(cfg_en), .cfg_assume_dtim(cfg_assume_dtim),
    .beacon_rx(beacon_rx), .more_bcast(more_bcast), .sleep_cmd(sleep_cmd),
    .awake(awake), .why_tim(why_tim), .why_dtim(why_dtim), .cab_wait(cab_wait)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", tag, now_t, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] wake_of(logic [TW-1:0] tu);
    return (tu << 3) - 32'd24;
  endfunction

  function automatic int pack_model();
    return {28'd0, m_st != 0, m_why_t, m_why_d, m_st == 2};
  endfunction

  task automatic tick();
    logic [TW-1:0] dt, dd;
    bit ht, hd, go, ex, tc;
    int ns;
    dt = now_t - m_wt;
    dd = now_t - m_wd;
    ht = m_armed && !dt[TW-1] && cfg_en;
    hd = m_armed && !dd[TW-1] && cfg_en;
    go = (m_st == 0) && (ht || hd);
    ex = (now_t - m_start) >= 32'd80;
    tc = more_bcast || (m_why_d && cfg_assume_dtim);
    ns = m_st;
    if (!cfg_en) ns = 0;
    else case (m_st)
      0: if (go) ns = 1;
      1: if (beacon_rx) ns = tc ? 2 : 3; else if (ex) ns = 0;
      2: if (!more_bcast && ex) ns = 0;
      default: if (sleep_cmd) ns = 0;
    endcase
    @(posedge clk);
    #1;
    if (go || (m_st == 1 && beacon_rx && tc) || (m_st == 2 && more_bcast)) m_start = now_t;
    if (cfg_load) begin
      m_wt = wake_of((cfg_tim_per == cfg_dtim_per) ? cfg_dtim_tu : cfg_tim_tu);
      m_wd = wake_of(cfg_dtim_tu);
      m_step_t = {13'd0, cfg_tim_per, 3'b000};
      m_step_d = {13'd0, cfg_dtim_per, 3'b000};
      m_armed = 1;
    end else begin
      if (ht) m_wt = m_wt + m_step_t;
      if (hd) m_wd = m_wd + m_step_d;
    end
    if (ns == 0) begin m_why_t = 0; m_why_d = 0; end
    else if (go) begin m_why_t = ht; m_why_d = hd; end
    m_st = ns;
    now_t = now_t + 1;
    chk("R10 cycle model", {28'd0, awake, why_tim, why_dtim, cab_wait}, pack_model());
  endtask

  task automatic wait_to(int t);
    while (now_t < t) tick();
  endtask

  task automatic pulse_sleep();
    sleep_cmd = 1; tick(); sleep_cmd = 0;
  endtask

  task automatic pulse_beacon();
    beacon_rx = 1; tick(); beacon_rx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 awake", awake, 0);
    chk("R1 reasons", {why_tim, why_dtim}, 0);
    chk("R1 cab_wait", cab_wait, 0);
    tick(); tick();
    chk("R1 no wake before load", awake, 0);

    // R2 load: ordinary target 10 TU, delivery 40 TU, periods 16/32
    cfg_tim_tu = 10; cfg_dtim_tu = 40; cfg_tim_per = 16; cfg_dtim_per = 32;
    cfg_assume_dtim = 1; cfg_en = 1; cfg_load = 1;
    tick(); cfg_load = 0;
    wait_to(56);  chk("R2 asleep before wake", awake, 0);
    tick();       chk("R2 awake at wake", awake, 1);
    chk("R10 why_tim", why_tim, 1); chk("R10 why_dtim", why_dtim, 0);
    wait_to(136); chk("R5 still waiting", awake, 1);
    tick();       chk("R5 beacon timeout", awake, 0);

    wait_to(184); chk("R4 asleep before advanced wake", awake, 0);
    tick();       chk("R4 advanced ordinary wake", awake, 1);
    wait_to(186); pulse_sleep();
    chk("R6 sleep ignored in beacon wait", awake, 1);
    wait_to(190); pulse_beacon();
    chk("R6 hold no window", cab_wait, 0);
    wait_to(250); chk("R6 hold past timeout", awake, 1);
    wait_to(260); pulse_sleep();
    chk("R6 sleep from hold", awake, 0);

    wait_to(297); chk("R4 delivery wake why_dtim", why_dtim, 1);
    chk("R4 delivery wake why_tim", why_tim, 0);
    wait_to(300); pulse_beacon();
    chk("R7 window after delivery beacon", cab_wait, 1);
    wait_to(380); chk("R8 window open", cab_wait, 1);
    tick();       chk("R8 window closes", awake, 0);

    wait_to(440); chk("R4 asleep before 440", awake, 0);
    tick();       chk("R4 ordinary advanced while awake", why_tim, 1);
    wait_to(445); more_bcast = 1; pulse_beacon();
    wait_to(471); more_bcast = 0;
    chk("R8 more_bcast opens window", cab_wait, 1);
    wait_to(550); chk("R8 window extended", awake, 1);
    tick();       chk("R8 extended window ends", awake, 0);

    wait_to(553); chk("R4 delivery period 256", why_dtim, 1);
    wait_to(555); pulse_beacon();

    // R3 equal periods align the ordinary schedule to the delivery target
    wait_to(640);
    cfg_tim_tu = 100; cfg_dtim_tu = 90; cfg_tim_per = 16; cfg_dtim_per = 16;
    cfg_assume_dtim = 0; cfg_load = 1;
    tick(); cfg_load = 0;
    wait_to(696); chk("R3 asleep before aligned wake", awake, 0);
    tick();
    chk("R3 aligned why_tim", why_tim, 1);
    chk("R3 aligned why_dtim", why_dtim, 1);
    wait_to(700); pulse_beacon();
    chk("R7 no assume gives hold", cab_wait, 0);
    wait_to(800); chk("R7 hold awake", awake, 1);
    wait_to(805); pulse_sleep();
    chk("R6 sleep command", awake, 0);
    wait_to(825);
    chk("R4 both advanced tim", why_tim, 1);
    chk("R4 both advanced dtim", why_dtim, 1);

    // R9 disable
    wait_to(830); cfg_en = 0; tick();
    chk("R9 disable sleeps", awake, 0);
    chk("R9 reasons cleared", {why_tim, why_dtim}, 0);
    wait_to(960); chk("R9 wake suppressed", awake, 0);
    wait_to(965);
    cfg_tim_tu = 130; cfg_dtim_tu = 140; cfg_tim_per = 20; cfg_dtim_per = 40;
    cfg_load = 1; tick(); cfg_load = 0;
    wait_to(970); cfg_en = 1;

    // random phase
    for (int i = 0; i < 15000; i++) begin
      beacon_rx  = ($urandom % 20) == 0;
      more_bcast = ($urandom % 25) == 0;
      sleep_cmd  = ($urandom % 40) == 0;
      cfg_assume_dtim = ($urandom % 2) == 0;
      if (($urandom % 4000) == 0) cfg_en = ~cfg_en;
      if (!cfg_en && ($urandom % 50) == 0) cfg_en = 1;
      if (($urandom % 3000) == 0) begin
        int k;
        k = 1 + ($urandom % 3);
        cfg_tim_per  = PW'(12 + ($urandom % 29));
        cfg_dtim_per = PW'(int'(cfg_tim_per) * k);
        cfg_tim_tu   = now_t / 8 + 6 + ($urandom % 10);
        cfg_dtim_tu  = now_t / 8 + 6 + ($urandom % 40);
        cfg_load = 1;
      end
      tick();
      cfg_load = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule